// File: doc/BRIEF.md
# March C- Memory Self-Test Engine

This block tests a small single-port synchronous RAM on its own. One pulse on `start` makes it walk the RAM through the six March C- elements. It issues exactly one memory operation per clock cycle. Each read is checked against the expected all-zeros or all-ones background. The RAM itself sits outside the block, and the engine drives its enable, write strobe, address and write data.

Every read that does not match is counted. The address of each distinct failing location goes into a small capture bank, in the order the failures are first seen. Logging runs alongside the march and adds no cycles to it. When the run is over, `done` and `pass` give the verdict. The captured addresses can then be read out one bit per `shift_en` cycle on `ser_out`.

Top module: `mbist_march_cm`

## Requirements
- R1: After a start, the memory port carries this operation order, where N = 2^ADDR_W:
  - Element 0: write 0 to every address, ascending.
  - Element 1: read 0 then write 1 at each address, ascending.
  - Element 2: read 1 then write 0 at each address, ascending.
  - Element 3: read 0 then write 1 at each address, descending.
  - Element 4: read 1 then write 0 at each address, descending.
  - Element 5: read 0 at every address, ascending.
  - "0" and "1" mean a word of all zeros or all ones.
- R2: The engine issues one operation per cycle, 10N in total. A write that follows a read goes to the same address in the next cycle. `done` rises exactly 10N+1 cycles after the cycle in which `start` is sampled, and `busy` is high from the march until then.
- R3: Read data is compared one cycle after the read is issued, and a mismatch in any bit is a failure. `fail_count` counts failing reads and saturates at its maximum.
- R4: The first failure at an address that is not yet in the bank stores that address in the next free entry, in capture order. A further failure at an address already stored is counted but not stored again.
- R5: A failure at a new address while all CAP_DEPTH entries are used sets `overflow` and leaves the bank unchanged.
- R6: When `busy` is low, every cycle with `shift_en` high moves `ser_out` on by one bit.
  - `ser_out` starts at the MSB of entry 0.
  - Each entry is sent MSB first, entries go out in capture order, and unused entries read as zeros.
  - `shift_en` is ignored while `busy` is high.
- R7: `done` holds until the next accepted start. `pass` is high only while `done` is high and no failure was recorded.
- R8: A start while `busy` is high is ignored. A start that is accepted clears the count, the bank, `overflow`, `done` and `pass`.
- R9: After reset the engine is idle. `busy`, `done`, `pass`, `overflow`, `mem_en` and `fail_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when not busy |
| busy | output | 1 | March in progress |
| done | output | 1 | Test finished, verdict valid |
| pass | output | 1 | Finished with no failure |
| fail_count | output | FCNT_W | Saturating count of failing reads |
| overflow | output | 1 | A new failing address did not fit in the bank |
| shift_en | input | 1 | Advance serial readout by one bit |
| ser_out | output | 1 | Serial readout of captured addresses |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write strobe (read when low) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the read |

## Verification
The bench builds the engine with ADDR_W=3, DATA_W=8, CAP_DEPTH=4 and FCNT_W=6. With these values a full march is only 80 operations long, so every operation can be checked against an independently computed order. Eight addresses are enough to place five faults, which fills the four-entry bank and reaches overflow. The faults are stuck bits at both ends of the word, and some are placed so that capture order differs from address order.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_DONE  = 2'd3
   } mbist_state_e;

   localparam int unsigned NUM_ELEM = 6;
   localparam logic [2:0]  LAST_ELEM = 3'(NUM_ELEM - 1);

   // element carries a read as its first operation
   function automatic logic elem_has_rd(input logic [2:0] e);
      return (e != 3'd0);
   endfunction

   // element carries a write
   function automatic logic elem_has_wr(input logic [2:0] e);
      return (e != LAST_ELEM);
   endfunction

   // element sweeps from the top address down
   function automatic logic elem_desc(input logic [2:0] e);
      return (e == 3'd3) || (e == 3'd4);
   endfunction

   // background bit expected on reads of this element
   function automatic logic elem_rd_val(input logic [2:0] e);
      return (e == 3'd2) || (e == 3'd4);
   endfunction

   // background bit written by this element
   function automatic logic elem_wr_val(input logic [2:0] e);
      return (e == 3'd1) || (e == 3'd3);
   endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_down,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              at_end
);

   logic [ADDR_W-1:0] addr_q;
   logic              down_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         down_q <= 1'b0;
      end else if (load) begin
         addr_q <= load_down ? '1 : '0;
         down_q <= load_down;
      end else if (step) begin
         addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
      end
   end

   assign addr   = addr_q;
   assign at_end = down_q ? (addr_q == '0) : (addr_q == '1);

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
   import mbist_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              clear,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              chk_v,
   output logic [ADDR_W-1:0] chk_addr,
   output logic [DATA_W-1:0] chk_exp
);

   mbist_state_e st_q;
   logic [2:0]   elem_q;
   logic         ph_q;
   logic         running, has_rd, has_wr, op_rd, op_wr;
   logic         addr_done, at_end, go, ld, ld_down, stp;
   logic [2:0]   elem_nx;
   logic [ADDR_W-1:0] addr;

   assign running   = (st_q == ST_RUN);
   assign has_rd    = elem_has_rd(elem_q);
   assign has_wr    = elem_has_wr(elem_q);
   assign op_rd     = running && has_rd && !ph_q;
   assign op_wr     = running && has_wr && (ph_q || !has_rd);
   assign addr_done = running && (ph_q || !(has_rd && has_wr));
   assign elem_nx   = elem_q + 3'd1;
   assign go        = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));
   assign ld        = go || (addr_done && at_end && (elem_q != LAST_ELEM));
   assign ld_down   = go ? 1'b0 : elem_desc(elem_nx);
   assign stp       = addr_done && !at_end;

   mbist_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld),
      .load_down (ld_down),
      .step      (stp),
      .addr      (addr),
      .at_end    (at_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         elem_q <= '0;
         ph_q   <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE, ST_DONE: if (go) begin
               st_q   <= ST_RUN;
               elem_q <= '0;
               ph_q   <= 1'b0;
            end
            ST_RUN: begin
               if (!addr_done) begin
                  ph_q <= 1'b1;
               end else begin
                  ph_q <= 1'b0;
                  if (at_end) begin
                     if (elem_q == LAST_ELEM) st_q <= ST_DRAIN;
                     else                     elem_q <= elem_nx;
                  end
               end
            end
            default: st_q <= ST_DONE;
         endcase
      end
   end

   // compare stage: aligned with the one-cycle read latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_v    <= 1'b0;
         chk_addr <= '0;
         chk_exp  <= '0;
      end else begin
         chk_v    <= op_rd;
         chk_addr <= addr;
         chk_exp  <= {DATA_W{elem_rd_val(elem_q)}};
      end
   end

   assign busy      = running || (st_q == ST_DRAIN);
   assign done      = (st_q == ST_DONE);
   assign clear     = go;
   assign mem_en    = op_rd || op_wr;
   assign mem_we    = op_wr;
   assign mem_addr  = addr;
   assign mem_wdata = {DATA_W{elem_wr_val(elem_q)}};

   // R2: a read inside a two-operation element is followed by a write to the same address
   p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we && elem_q >= 3'd1 && elem_q <= 3'd4)
      |=> (mem_en && mem_we && mem_addr == $past(mem_addr)));

   // R8: start while busy does not restart the march
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && elem_q != 3'd0) |=> (elem_q != 3'd0));

   // R7: done holds until a new start
   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R1: only background words are written
   p_wdata_bg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> (mem_wdata == '0 || mem_wdata == '1));

endmodule

// File: rtl/mbist_fail_log.sv
module mbist_fail_log #(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CAP_DEPTH = 4,
   parameter int unsigned FCNT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              busy,
   input  logic              chk_v,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic [DATA_W-1:0] chk_exp,
   input  logic [DATA_W-1:0] rdata,
   input  logic              shift_en,
   output logic [FCNT_W-1:0] fail_cnt,
   output logic              ovf,
   output logic              ser_out
);

   localparam int unsigned BANK_W = CAP_DEPTH * ADDR_W;
   localparam int unsigned CNT_W  = $clog2(CAP_DEPTH + 1);

   logic [BANK_W-1:0]    bank_q;
   logic [CNT_W-1:0]     cap_n;
   logic [CAP_DEPTH-1:0] hit;
   logic                 miss, dup, full;

   assign miss = chk_v && (rdata != chk_exp);

   for (genvar g = 0; g < CAP_DEPTH; g++) begin : g_match
      assign hit[g] = (CNT_W'(g) < cap_n)
                   && (bank_q[(CAP_DEPTH-g)*ADDR_W-1 -: ADDR_W] == chk_addr);
   end

   assign dup  = |hit;
   assign full = (cap_n == CNT_W'(CAP_DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q   <= '0;
         cap_n    <= '0;
         ovf      <= 1'b0;
         fail_cnt <= '0;
      end else if (clear) begin
         bank_q   <= '0;
         cap_n    <= '0;
         ovf      <= 1'b0;
         fail_cnt <= '0;
      end else if (miss) begin
         if (fail_cnt != '1) fail_cnt <= fail_cnt + 1'b1;
         if (!dup) begin
            if (full) begin
               ovf <= 1'b1;
            end else begin
               for (int g = 0; g < CAP_DEPTH; g++)
                  if (cap_n == CNT_W'(g))
                     bank_q[(CAP_DEPTH-g)*ADDR_W-1 -: ADDR_W] <= chk_addr;
               cap_n <= cap_n + 1'b1;
            end
         end
      end else if (shift_en && !busy) begin
         bank_q <= {bank_q[BANK_W-2:0], 1'b0};
      end
   end

   assign ser_out = bank_q[BANK_W-1];

   // R5: overflow only rises once every entry is used
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> ($past(cap_n) == CNT_W'(CAP_DEPTH)));

   // R4: a repeated failing address leaves the occupancy unchanged
   p_dup_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (miss && dup) |=> (cap_n == $past(cap_n)));

   // R3: the failure count never decreases without a clear
   p_cnt_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (fail_cnt >= $past(fail_cnt)));

endmodule

// File: rtl/mbist_march_cm.sv
module mbist_march_cm #(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CAP_DEPTH = 4,
   parameter int unsigned FCNT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic [FCNT_W-1:0] fail_count,
   output logic              overflow,
   input  logic              shift_en,
   output logic              ser_out,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_aw
      $fatal(1, "ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $fatal(1, "DATA_W must be positive");
   end
   if (CAP_DEPTH < 1 || CAP_DEPTH > 64) begin : g_bad_cd
      $fatal(1, "CAP_DEPTH out of range");
   end
   if (FCNT_W < 1) begin : g_bad_fw
      $fatal(1, "FCNT_W must be positive");
   end

   logic              clear, chk_v;
   logic [ADDR_W-1:0] chk_addr;
   logic [DATA_W-1:0] chk_exp;

   mbist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .busy      (busy),
      .done      (done),
      .clear     (clear),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .chk_v     (chk_v),
      .chk_addr  (chk_addr),
      .chk_exp   (chk_exp)
   );

   mbist_fail_log #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAP_DEPTH(CAP_DEPTH), .FCNT_W(FCNT_W)
   ) u_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .busy     (busy),
      .chk_v    (chk_v),
      .chk_addr (chk_addr),
      .chk_exp  (chk_exp),
      .rdata    (mem_rdata),
      .shift_en (shift_en),
      .fail_cnt (fail_count),
      .ovf      (overflow),
      .ser_out  (ser_out)
   );

   assign pass = done && (fail_count == '0);

   // R7: pass never shows while the march is still running
   p_pass_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !pass);

endmodule

// File: tb/mbist_march_cm_tb_top.sv
module mbist_march_cm_tb_top;

   localparam int AW = 3;
   localparam int DW = 8;
   localparam int CD = 4;
   localparam int FW = 6;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          shift_en = 1'b0;
   logic          busy, done, pass, overflow, ser_out, mem_en, mem_we;
   logic [FW-1:0] fail_count;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   logic [DW-1:0] ram   [NW];
   logic [DW-1:0] sa1_m [NW];
   logic [DW-1:0] sa0_m [NW];

   int errors = 0;
   int checks = 0;
   int op_idx = 0;
   int mism   = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   mbist_march_cm #(.ADDR_W(AW), .DATA_W(DW), .CAP_DEPTH(CD), .FCNT_W(FW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .pass(pass), .fail_count(fail_count), .overflow(overflow),
      .shift_en(shift_en), .ser_out(ser_out), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // RAM model with stuck-at faults applied on reads
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) ram[mem_addr] <= mem_wdata;
         else        mem_rdata <= (ram[mem_addr] | sa1_m[mem_addr]) & ~sa0_m[mem_addr];
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected march operation from R1/R2
   task automatic exp_op(input int i, output bit we, output int a, output bit v);
      if (i < NW) begin
         we = 1'b1; a = i; v = 1'b0;
      end else if (i < 9*NW) begin
         int j, e, k, ai;
         bit rv;
         j  = i - NW;
         e  = 1 + j / (2*NW);
         k  = j % (2*NW);
         ai = k / 2;
         a  = (e <= 2) ? ai : NW - 1 - ai;
         rv = (e == 2 || e == 4);
         we = (k % 2 == 1);
         v  = we ? !rv : rv;
      end else begin
         we = 1'b0; a = i - 9*NW; v = 1'b0;
      end
   endtask

   always @(negedge clk) begin
      if (mem_en) begin
         bit we, v;
         int a;
         exp_op(op_idx, we, a, v);
         if (mem_we !== we || int'(mem_addr) != a || (we && mem_wdata !== {DW{v}}))
            mism++;
         op_idx++;
      end
   end

   // watchdog
   always @(negedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL R2 watchdog actual=%0d expected=done", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic clear_faults();
      for (int i = 0; i < NW; i++) begin
         sa1_m[i] = '0;
         sa0_m[i] = '0;
      end
   endtask

   // start a march and return cycles until done; optional mid-run restart pulse
   task automatic run_march(input int poke_at, output int n);
      op_idx = 0;
      mism   = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      n = 0;
      while (!done && n < 400) begin
         @(negedge clk);
         n++;
         if (n == poke_at) start = 1'b1;
         else              start = 1'b0;
      end
      start = 1'b0;
   endtask

   task automatic read_bank(output logic [CD*AW-1:0] bits);
      for (int i = CD*AW-1; i >= 0; i--) begin
         bits[i] = ser_out;
         shift_en = 1'b1;
         @(negedge clk);
      end
      shift_en = 1'b0;
   endtask

   task automatic t_reset();
      check(!busy && !done && !pass, "R9 idle flags", {busy, done, pass}, 0);
      check(!mem_en && !overflow, "R9 mem_en/overflow", {mem_en, overflow}, 0);
      check(fail_count == 0, "R9 fail_count", fail_count, 0);
   endtask

   task automatic t_clean();
      int n;
      clear_faults();
      run_march(0, n);
      check(n == 10*NW + 1, "R2 done latency", n, 10*NW + 1);
      check(op_idx == 10*NW, "R2 op count", op_idx, 10*NW);
      check(mism == 0, "R1 op order", mism, 0);
      check(pass && fail_count == 0 && !overflow, "R7 clean pass", {pass, overflow}, 2);
      repeat (3) @(negedge clk);
      check(done && pass, "R7 done holds", {done, pass}, 3);
   endtask

   task automatic t_single_sa1();
      int n;
      logic [CD*AW-1:0] bits;
      clear_faults();
      sa1_m[5] = 8'h80;
      shift_en = 1'b1;
      run_march(0, n);
      shift_en = 1'b0;
      check(!pass && done, "R7 fail verdict", pass, 0);
      check(fail_count == 3, "R3 sa1 count", fail_count, 3);
      check(!overflow, "R5 no overflow", overflow, 0);
      read_bank(bits);
      check(bits == {3'd5, 3'd0, 3'd0, 3'd0}, "R6 readout and shift ignored while busy", bits, {3'd5, 9'd0});
      check(bits[CD*AW-1 -: AW] == 3'd5, "R4 single capture", bits[CD*AW-1 -: AW], 5);
   endtask

   task automatic t_mixed();
      int n;
      logic [CD*AW-1:0] bits;
      clear_faults();
      sa0_m[2] = 8'h01;
      sa1_m[6] = 8'h80;
      run_march(0, n);
      check(fail_count == 5, "R3 mixed count", fail_count, 5);
      read_bank(bits);
      check(bits == {3'd6, 3'd2, 3'd0, 3'd0}, "R4 capture order", bits, {3'd6, 3'd2, 6'd0});
   endtask

   task automatic t_overflow();
      int n;
      logic [CD*AW-1:0] bits;
      clear_faults();
      sa1_m[0] = 8'h01; sa1_m[1] = 8'h10; sa1_m[3] = 8'h80;
      sa1_m[4] = 8'h02; sa1_m[7] = 8'h40;
      run_march(0, n);
      check(overflow, "R5 overflow set", overflow, 1);
      check(fail_count == 15, "R3 overflow count", fail_count, 15);
      read_bank(bits);
      check(bits == {3'd0, 3'd1, 3'd3, 3'd4}, "R5 bank unchanged", bits, {3'd0, 3'd1, 3'd3, 3'd4});
   endtask

   task automatic t_restart_ignored();
      int n;
      clear_faults();
      run_march(20, n);
      check(n == 10*NW + 1, "R8 start ignored while busy", n, 10*NW + 1);
      check(mism == 0 && op_idx == 10*NW, "R8 op order unchanged", mism, 0);
      check(pass && !overflow && fail_count == 0, "R8 results cleared", fail_count, 0);
   endtask

   initial begin
      clear_faults();
      for (int i = 0; i < NW; i++) ram[i] = 8'h5a;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_single_sa1();
      t_mixed();
      t_overflow();
      t_restart_ignored();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule